// File: doc/BRIEF.md
# Supply-Tracking Gain Attenuation Controller

This block produces a digital attenuation code for an audio output stage. It holds the output near a chosen power target and keeps it clear of clipping while the supply droops. Each cycle it reads two digitised magnitudes. The first is the present output peak. The second is the headroom the supply can currently deliver. The regulation limit is the smaller of the headroom and the target that belongs to the selected mode. The limit therefore falls as the supply sags, and the code rises to follow it.

The code counts in 0.5 dB steps. It climbs one step per attack period while the peak is above the limit. It falls one step per release period while the peak sits clearly below the limit. A free-running prescaler produces both periods from the system clock. By default the attack period lets the full range build up in about 40 ms, and the release period lets it decay in about 1.5 s. One mode turns regulation off. Dropping the enable, or changing mode, clears the code and restarts both prescalers.

Top module: `supply_agc`

## Requirements
- R1: After reset `atten_o` is 0.
- R2: While `peak_i` is above the limit, `atten_o` rises by exactly one code per `ATK_CYC` clock cycles and never by more than one per cycle.
- R3: `atten_o` never exceeds `MAX_CODE` (27, i.e. 13.5 dB). It stays at 27 under a sustained overload.
- R4: While `peak_i + HYST` is below the limit, `atten_o` falls by exactly one code per `REL_CYC` clock cycles and stops at 0.
- R5: When `peak_i` lies between `limit - HYST` and `limit` (both ends included), `atten_o` holds its value.
- R6: The limit is min(`headroom_i`, target). The target is `TGT_HI` for mode code 0, `TGT_MID` for code 1 and `TGT_LO` for code 2.
- R7: With mode code 3 (bypass), `atten_o` is 0 from the next cycle on, whatever the peak.
- R8: A change of `mode_i` sets `atten_o` to 0 at the next edge. The first new attack step then comes exactly `ATK_CYC` cycles after that edge.
- R9: With `en_i` low, `atten_o` is 0 from the next cycle on and both prescalers are held. After `en_i` returns high, the first attack step comes `ATK_CYC` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulation enable |
| mode_i | input | 2 | Mode code: 0/1/2 power targets, 3 bypass |
| peak_i | input | PW | Sampled output peak magnitude |
| headroom_i | input | PW | Sampled supply headroom magnitude |
| atten_o | output | AW | Attenuation code, 0.5 dB per step |

## Verification
Some properties are checked on every cycle by the assertions. The code never passes the ceiling and never moves by more than one step in a cycle. A rise is always preceded by an overload and a fall by a clear underload. The code holds inside the hysteresis band. Bypass, a low enable and a change of mode all empty the code at the next edge. Other behaviour only the directed scenarios can show: the exact step rate over windows of whole periods, how the limit follows the headroom and the mode target, and the restart of the prescaler phase after a mode change or a re-enable.

// File: rtl/supply_agc_pkg.sv
package supply_agc_pkg;
  typedef enum logic [1:0] {
    MODE_HI  = 2'd0,
    MODE_MID = 2'd1,
    MODE_LO  = 2'd2,
    MODE_BYP = 2'd3
  } agc_mode_e;
endpackage

// File: rtl/agc_tick_gen.sv
module agc_tick_gen #(
  parameter int unsigned PERIOD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || cnt_q == LAST) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == LAST);

  assert_tick_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/agc_limit_sel.sv
module agc_limit_sel import supply_agc_pkg::*; #(
  parameter int unsigned PW      = 8,
  parameter int unsigned HYST    = 4,
  parameter int unsigned TGT_HI  = 200,
  parameter int unsigned TGT_MID = 180,
  parameter int unsigned TGT_LO  = 160
) (
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] peak_i,
  input  logic [PW-1:0] headroom_i,
  output logic [PW-1:0] limit_o,
  output logic          over_o,
  output logic          under_o
);
  logic [PW-1:0] tgt;
  logic [PW:0]   peak_hyst;

  always_comb begin
    unique case (agc_mode_e'(mode_i))
      MODE_HI:  tgt = PW'(TGT_HI);
      MODE_MID: tgt = PW'(TGT_MID);
      MODE_LO:  tgt = PW'(TGT_LO);
      default:  tgt = '1;
    endcase
  end

  // supply-derived ceiling wins when it is lower than the power target
  assign limit_o   = (headroom_i < tgt) ? headroom_i : tgt;
  assign peak_hyst = {1'b0, peak_i} + (PW+1)'(HYST);
  assign over_o    = peak_i > limit_o;
  assign under_o   = peak_hyst < {1'b0, limit_o};
endmodule

// File: rtl/agc_atten_step.sv
module agc_atten_step #(
  parameter int unsigned AW       = 5,
  parameter int unsigned MAX_CODE = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          atk_tick_i,
  input  logic          rel_tick_i,
  input  logic          over_i,
  input  logic          under_i,
  output logic [AW-1:0] atten_o
);
  localparam logic [AW-1:0] CEIL = AW'(MAX_CODE);

  logic [AW-1:0] atten_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        atten_q <= '0;
    else if (clr_i)                                     atten_q <= '0;
    else if (atk_tick_i && over_i && atten_q < CEIL)    atten_q <= atten_q + 1'b1;
    else if (rel_tick_i && under_i && atten_q != '0)    atten_q <= atten_q - 1'b1;
  end

  assign atten_o = atten_q;

  assert_ceiling_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atten_q <= CEIL);
endmodule

// File: rtl/supply_agc.sv
module supply_agc import supply_agc_pkg::*; #(
  parameter int unsigned PW         = 8,
  parameter int unsigned AW         = 5,
  parameter int unsigned MAX_CODE   = 27,
  parameter int unsigned CLK_KHZ    = 250000,
  parameter int unsigned ATTACK_MS  = 40,
  parameter int unsigned RELEASE_MS = 1500,
  parameter int unsigned ATK_CYC    = CLK_KHZ * ATTACK_MS / MAX_CODE,
  parameter int unsigned REL_CYC    = CLK_KHZ * RELEASE_MS / MAX_CODE,
  parameter int unsigned HYST       = 4,
  parameter int unsigned TGT_HI     = 200,
  parameter int unsigned TGT_MID    = 180,
  parameter int unsigned TGT_LO     = 160
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] peak_i,
  input  logic [PW-1:0] headroom_i,
  output logic [AW-1:0] atten_o
);
  logic [1:0]    mode_q;
  logic [PW-1:0] limit;
  logic          over, under, clr, atk_tick, rel_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_BYP;
    else         mode_q <= mode_i;
  end

  assign clr = !en_i || (mode_i == MODE_BYP) || (mode_i != mode_q);

  agc_limit_sel #(
    .PW(PW), .HYST(HYST), .TGT_HI(TGT_HI), .TGT_MID(TGT_MID), .TGT_LO(TGT_LO)
  ) u_limit (
    .mode_i(mode_i), .peak_i(peak_i), .headroom_i(headroom_i),
    .limit_o(limit), .over_o(over), .under_o(under)
  );

  agc_tick_gen #(.PERIOD(ATK_CYC)) u_atk_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .tick_o(atk_tick)
  );

  agc_tick_gen #(.PERIOD(REL_CYC)) u_rel_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .tick_o(rel_tick)
  );

  agc_atten_step #(.AW(AW), .MAX_CODE(MAX_CODE)) u_step (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .atk_tick_i(atk_tick), .rel_tick_i(rel_tick),
    .over_i(over), .under_i(under), .atten_o(atten_o)
  );

  assert_bypass_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BYP) |=> (atten_o == '0));

  assert_enable_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (atten_o == '0));

  assert_mode_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != mode_q) |=> (atten_o == '0));

  assert_rise_on_over_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atten_o > $past(atten_o)) |-> ($past(peak_i) > $past(limit)));

  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atten_o > $past(atten_o)) |-> (atten_o == $past(atten_o) + 1'b1));

  assert_fall_on_under_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((atten_o < $past(atten_o)) && !$past(clr)) |-> $past(under));

  assert_hold_band_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr && !over && !under) |=> $stable(atten_o));
endmodule

// File: tb/supply_agc_bench.sv
module supply_agc_bench;
  localparam int ATK = 6;
  localparam int REL = 15;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic [1:0] mode_i = 2'd3;
  logic [7:0] peak_i = '0;
  logic [7:0] headroom_i = 8'd255;
  logic [4:0] atten_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supply_agc #(.ATK_CYC(ATK), .REL_CYC(REL)) u_supply_agc (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
    .peak_i(peak_i), .headroom_i(headroom_i), .atten_o(atten_o)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: atten_o=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    check("R1 reset", atten_o, 0);
  endtask

  task automatic t_attack;
    mode_i = 2'd0; peak_i = 8'd220;
    edges(1 + 3*ATK);
    check("R2 attack 3 periods", atten_o, 3);
    edges(2*ATK);
    check("R2 attack 5 periods", atten_o, 5);
  endtask

  task automatic t_hold;
    peak_i = 8'd200;
    edges(3*REL);
    check("R5 hold at limit", atten_o, 5);
    peak_i = 8'd196;
    edges(3*REL);
    check("R5 hold at limit-hyst", atten_o, 5);
  endtask

  task automatic t_release;
    peak_i = 8'd195;
    edges(2*REL);
    check("R4 release 2 periods", atten_o, 3);
    edges(3*REL);
    check("R4 release to zero", atten_o, 0);
    edges(2*REL);
    check("R4 stays at zero", atten_o, 0);
  endtask

  task automatic t_saturate;
    peak_i = 8'd255;
    edges(30*ATK);
    check("R3 saturate", atten_o, 27);
    edges(3*ATK);
    check("R3 stays at ceiling", atten_o, 27);
  endtask

  task automatic t_supply;
    mode_i = 2'd1; peak_i = 8'd170; headroom_i = 8'd160;
    edges(1 + 2*ATK);
    check("R6 headroom lowers limit", atten_o, 2);
    headroom_i = 8'd255;
    edges(REL);
    check("R6 target limit releases", atten_o, 1);
    mode_i = 2'd2;
    edges(1 + ATK);
    check("R6 low target attacks", atten_o, 1);
  endtask

  task automatic t_mode_change;
    edges(3);
    mode_i = 2'd0; peak_i = 8'd220;
    edges(1);
    check("R8 mode change clears", atten_o, 0);
    edges(ATK - 1);
    check("R8 no early step", atten_o, 0);
    edges(1);
    check("R8 step after full period", atten_o, 1);
  endtask

  task automatic t_enable;
    en_i = 1'b0;
    edges(1);
    check("R9 disable clears", atten_o, 0);
    edges(3*ATK);
    check("R9 held while disabled", atten_o, 0);
    en_i = 1'b1;
    edges(ATK - 1);
    check("R9 no early step", atten_o, 0);
    edges(1);
    check("R9 step after re-enable", atten_o, 1);
  endtask

  task automatic t_bypass;
    mode_i = 2'd3; peak_i = 8'd255;
    edges(1);
    check("R7 bypass clears", atten_o, 0);
    edges(5*ATK);
    check("R7 bypass stays zero", atten_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_attack();
    t_hold();
    t_release();
    t_saturate();
    t_supply();
    t_mode_change();
    t_enable();
    t_bypass();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule